// File: doc/BRIEF.md
# Speculative Two-Phase Stage Controller

This is the control element of one stage in a pipeline that hands data forward speculatively. It is modelled on a clock, and every delay is counted in clock ticks. A token arrives as a transition on the left request. The controller then asks the previous stage, over a pull-only extend channel, whether that stage's own capture was clean. It opens its latch once the answer is in, and forwards the token to the right after the short delay. If the answer comes back late, the latch opening and the forwarding are both pushed back by the long delay.

The controller also serves the next stage's extend requests. It checks the dual-rail error indication from its own capture stage and answers at once when clean, or after the long delay when an error is flagged. While the rails are neutral it holds the answer back.

Both delays are programmable. A configuration whose long delay exceeds its short delay, or whose short delay is below two ticks, is flagged, and the controller takes no new tokens while it stands.

Top module: `spec_hs_ctrl`

## Requirements
- R1: While reset is applied, and right after it, `l_ack_o`, `le_req_o`, `r_req_o`, `re_ack_o` and `latch_en_o` are all low.
- R2: A token is pending when `l_req_i` differs from `l_ack_o`. The controller accepts it at a clock edge and toggles `le_req_o` at that edge (edge T0). `latch_en_o` does not rise while `le_ack_i` differs from `le_req_o`.
- R3: The extend answer is on time when `le_ack_i` equals `le_req_o` at edge T0+1. In that case `latch_en_o` rises at T0+1, and `r_req_o` and `l_ack_o` toggle together at edge T0+δ.
- R4: The extend answer is late when it is first seen at edge T0+L with L≥2. In that case the latch opens at edge T0+max(L,Δ). `r_req_o` and `l_ack_o` toggle at edge T0+max(δ+Δ, max(L,Δ)+1).
- R5: Rail encoding: `err_t_i`=1 means error, `err_f_i`=1 with `err_t_i`=0 means clean, and both low means neutral. When the rails are clean, a pending extend request (`re_req_i` differs from `re_ack_o`) is answered by toggling `re_ack_o` at the edge where it is first seen.
- R6: When `err_t_i` is high at that edge, `re_ack_o` toggles Δ edges later, or at once if Δ is 0. `err_t_i` takes priority over `err_f_i`.
- R7: While the rails are neutral and no delayed answer is under way, `re_ack_o` does not change.
- R8: `cfg_bad_o` is high exactly when Δ>δ or δ<2. While it is high, no token is accepted: `le_req_o` and `l_ack_o` hold.
- R9: No token is accepted while `r_req_o` differs from `r_ack_i`. `l_ack_o` never toggles in that state.
- R10: `r_req_o` toggles only while `latch_en_o` is high, and the latch closes at the edge where the token is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_short_i | input | CNT_W | Short delay δ in ticks |
| cfg_long_i | input | CNT_W | Long delay Δ in ticks |
| cfg_bad_o | output | 1 | Delay setting is illegal |
| l_req_i | input | 1 | Left request, transition-signalled |
| l_ack_o | output | 1 | Left acknowledge, transition-signalled |
| le_req_o | output | 1 | Extend request to the previous stage |
| le_ack_i | input | 1 | Extend acknowledge from the previous stage |
| r_req_o | output | 1 | Right request, issued speculatively |
| r_ack_i | input | 1 | Right acknowledge |
| re_req_i | input | 1 | Extend request from the next stage |
| re_ack_o | output | 1 | Extend acknowledge to the next stage |
| err_t_i | input | 1 | Error rail: error seen |
| err_f_i | input | 1 | Error rail: capture clean |
| latch_en_o | output | 1 | Latch transparent when high |

## Verification
The bench builds the controller with the default CNT_W of 4. It sweeps every legal pair with δ from 2 to 5 and Δ from 0 to δ. That range covers the Δ=0 and Δ=δ edges and the smallest short delay. Each pair is run with an on-time extend answer, an answer two ticks late, and an answer arriving after the nominal forward time, so that both terms of the max in R4 become the deciding one. Illegal settings, neutral rails, both rails high, and a stalled right acknowledge are each driven on their own.

// File: rtl/spec_hs_pkg.sv
package spec_hs_pkg;
  localparam int unsigned MinShort = 2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FIRST = 2'd1,
    S_HOLD  = 2'd2
  } fwd_state_e;
endpackage

// File: rtl/spec_cfg_chk.sv
module spec_cfg_chk #(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] dly_short_i,
  input  logic [CNT_W-1:0] dly_long_i,
  output logic             cfg_ok_o
);
  import spec_hs_pkg::*;

  // error is sampled after the long window, which must end before the short one
  always_comb begin
    cfg_ok_o = (32'(dly_short_i) >= MinShort) && (dly_long_i <= dly_short_i);
  end
endmodule

// File: rtl/spec_fwd_path.sv
module spec_fwd_path #(
  parameter int unsigned CNT_W = 4,
  localparam int unsigned EL_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_ok_i,
  input  logic [CNT_W-1:0] dly_short_i,
  input  logic [CNT_W-1:0] dly_long_i,
  input  logic             l_req_i,
  output logic             l_ack_o,
  output logic             le_req_o,
  input  logic             le_ack_i,
  output logic             r_req_o,
  input  logic             r_ack_i,
  output logic             latch_en_o
);
  import spec_hs_pkg::*;

  fwd_state_e      state_q;
  logic [EL_W-1:0] elapsed_q;
  logic [EL_W-1:0] target;
  logic [EL_W-1:0] open_at;
  logic            late_q;
  logic            late_now;
  logic            ack_ok;
  logic            new_tok;
  logic            r_idle;

  always_comb begin
    ack_ok   = (le_ack_i == le_req_o);
    late_now = (state_q == S_FIRST) ? !ack_ok : late_q;
    // one counter serves both the short and the appended long interval
    target   = late_now ? (EL_W'(dly_short_i) + EL_W'(dly_long_i)) : EL_W'(dly_short_i);
    open_at  = late_now ? EL_W'(dly_long_i) : '0;
    new_tok  = (l_req_i != l_ack_o);
    r_idle   = (r_req_o == r_ack_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      elapsed_q  <= '0;
      late_q     <= 1'b0;
      l_ack_o    <= 1'b0;
      le_req_o   <= 1'b0;
      r_req_o    <= 1'b0;
      latch_en_o <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (new_tok && r_idle && cfg_ok_i) begin
            le_req_o  <= ~le_req_o;
            elapsed_q <= EL_W'(1);
            late_q    <= 1'b0;
            state_q   <= S_FIRST;
          end
        end
        default: begin
          late_q  <= late_now;
          state_q <= S_HOLD;
          if (latch_en_o && (elapsed_q >= target)) begin
            r_req_o    <= ~r_req_o;
            l_ack_o    <= ~l_ack_o;
            latch_en_o <= 1'b0;
            state_q    <= S_IDLE;
          end else begin
            if (ack_ok && (elapsed_q >= open_at)) latch_en_o <= 1'b1;
            if (elapsed_q != '1) elapsed_q <= elapsed_q + EL_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spec_ext_resp.sv
module spec_ext_resp #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] dly_long_i,
  input  logic             re_req_i,
  input  logic             err_t_i,
  input  logic             err_f_i,
  output logic             re_ack_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend;

  always_comb pend = (re_req_i != re_ack_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_ack_o <= 1'b0;
      busy_o   <= 1'b0;
      cnt_q    <= '0;
    end else if (!busy_o) begin
      if (pend && err_t_i) begin
        if (dly_long_i == '0) begin
          re_ack_o <= ~re_ack_o;
        end else begin
          busy_o <= 1'b1;
          cnt_q  <= CNT_W'(1);
        end
      end else if (pend && err_f_i) begin
        re_ack_o <= ~re_ack_o;
      end
    end else if (cnt_q >= dly_long_i) begin
      re_ack_o <= ~re_ack_o;
      busy_o   <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spec_hs_ctrl.sv
module spec_hs_ctrl #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cfg_short_i,
  input  logic [CNT_W-1:0] cfg_long_i,
  output logic             cfg_bad_o,
  input  logic             l_req_i,
  output logic             l_ack_o,
  output logic             le_req_o,
  input  logic             le_ack_i,
  output logic             r_req_o,
  input  logic             r_ack_i,
  input  logic             re_req_i,
  output logic             re_ack_o,
  input  logic             err_t_i,
  input  logic             err_f_i,
  output logic             latch_en_o
);
  logic cfg_ok;
  logic re_busy;

  spec_cfg_chk #(.CNT_W(CNT_W)) u_cfg (
    .dly_short_i (cfg_short_i),
    .dly_long_i  (cfg_long_i),
    .cfg_ok_o    (cfg_ok)
  );

  assign cfg_bad_o = !cfg_ok;

  spec_fwd_path #(.CNT_W(CNT_W)) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_ok_i    (cfg_ok),
    .dly_short_i (cfg_short_i),
    .dly_long_i  (cfg_long_i),
    .l_req_i     (l_req_i),
    .l_ack_o     (l_ack_o),
    .le_req_o    (le_req_o),
    .le_ack_i    (le_ack_i),
    .r_req_o     (r_req_o),
    .r_ack_i     (r_ack_i),
    .latch_en_o  (latch_en_o)
  );

  spec_ext_resp #(.CNT_W(CNT_W)) u_ext (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dly_long_i (cfg_long_i),
    .re_req_i   (re_req_i),
    .err_t_i    (err_t_i),
    .err_f_i    (err_f_i),
    .re_ack_o   (re_ack_o),
    .busy_o     (re_busy)
  );
endmodule

// File: rtl/spec_hs_ctrl_chk.sv
module spec_hs_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_bad_o,
  input logic l_ack_o,
  input logic le_req_o,
  input logic le_ack_i,
  input logic r_req_o,
  input logic r_ack_i,
  input logic re_req_i,
  input logic re_ack_o,
  input logic err_t_i,
  input logic err_f_i,
  input logic latch_en_o,
  input logic re_busy
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!l_ack_o && !le_req_o && !r_req_o && !re_ack_o && !latch_en_o); // R1
    end
  end

  AST_NO_OPEN_BEFORE_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_req_o != le_ack_i) |=> !$rose(latch_en_o)); // R2

  AST_FWD_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(r_req_o) == $stable(l_ack_o)); // R3

  AST_CLEAN_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((re_req_i != re_ack_o) && err_f_i && !err_t_i && !re_busy) |=> (re_ack_o != $past(re_ack_o))); // R5

  AST_NEUTRAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_t_i && !err_f_i && !re_busy) |=> $stable(re_ack_o)); // R7

  AST_BAD_CFG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad_o |=> $stable(le_req_o)); // R8

  AST_RIGHT_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_req_o != r_ack_i) |=> $stable(l_ack_o)); // R9

  AST_FWD_WHILE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_en_o |=> $stable(r_req_o)); // R10

  AST_CLOSE_ON_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(r_req_o) |-> !latch_en_o); // R10
endmodule

bind spec_hs_ctrl spec_hs_ctrl_chk u_chk (.*);

// File: tb/tb_spec_hs_ctrl.sv
module tb_spec_hs_ctrl;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_short = 4'd2;
  logic [CW-1:0] cfg_long = 4'd1;
  logic          cfg_bad;
  logic          l_req = 1'b0;
  logic          l_ack;
  logic          le_req;
  logic          le_ack = 1'b0;
  logic          r_req;
  logic          r_ack = 1'b0;
  logic          re_req = 1'b0;
  logic          re_ack;
  logic          err_t = 1'b0;
  logic          err_f = 1'b0;
  logic          latch_en;

  int n_chk = 0;
  int n_fail = 0;
  int up_lat = 1;
  int up_cnt = 0;
  bit dn_auto = 1'b1;
  int cyc = 0;

  always #2 clk = ~clk;

  spec_hs_ctrl #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_short_i(cfg_short), .cfg_long_i(cfg_long),
    .cfg_bad_o(cfg_bad), .l_req_i(l_req), .l_ack_o(l_ack), .le_req_o(le_req),
    .le_ack_i(le_ack), .r_req_o(r_req), .r_ack_i(r_ack), .re_req_i(re_req),
    .re_ack_o(re_ack), .err_t_i(err_t), .err_f_i(err_f), .latch_en_o(latch_en)
  );

  // previous stage: answers extend requests after up_lat falling edges
  always @(negedge clk) begin
    if (le_req != le_ack) begin
      up_cnt = up_cnt + 1;
      if (up_cnt >= up_lat) begin
        le_ack = le_req;
        up_cnt = 0;
      end
    end
  end

  // next stage: takes tokens at once when enabled
  always @(negedge clk) begin
    if (dn_auto && (r_req != r_ack)) r_ack = r_req;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_fwd(input int lat);
    int d = int'(cfg_short);
    int w = int'(cfg_long);
    int open_e;
    int fwd_e;
    int n = 0;
    bit done = 1'b0;
    logic le0;
    logic r0;
    logic l0;
    string tag;
    if (lat <= 1) begin
      open_e = 1; fwd_e = d; tag = "R3";
    end else begin
      open_e = imax(lat, w); fwd_e = imax(d + w, open_e + 1); tag = "R4";
    end
    @(negedge clk);
    up_lat = lat;
    le0 = le_req; r0 = r_req; l0 = l_ack;
    l_req = ~l_req;
    while (!done && n < 60) begin
      @(posedge clk);
      @(negedge clk);
      n = n + 1;
      if (n == 1) check(le_req != le0, "R2 extend request issued", int'(le_req), int'(~le0));
      if (n == open_e) check(latch_en == 1'b0, {tag, " latch still shut"}, int'(latch_en), 0);
      if (n == fwd_e) check(latch_en == 1'b1, {tag, " latch open before forward"}, int'(latch_en), 1);
      if (r_req != r0) done = 1'b1;
    end
    check(n - 1 == fwd_e, {tag, " forward delay"}, n - 1, fwd_e);
    check(l_ack == l_req, {tag, " left ack with forward"}, int'(l_ack), int'(l_req));
    check(latch_en == 1'b0, "R10 latch closed on forward", int'(latch_en), 0);
  endtask

  // mode 0 clean, 1 error, 2 both rails high
  task automatic run_ext(input int mode);
    int w = int'(cfg_long);
    int exp_n;
    int n = 0;
    bit done = 1'b0;
    logic a0;
    string tag;
    if (mode == 0) begin exp_n = 1; tag = "R5"; end
    else begin exp_n = (w == 0) ? 1 : w + 1; tag = "R6"; end
    @(negedge clk);
    err_t = (mode != 0);
    err_f = (mode != 1);
    a0 = re_ack;
    re_req = ~re_req;
    while (!done && n < 40) begin
      @(posedge clk);
      @(negedge clk);
      n = n + 1;
      if (re_ack != a0) done = 1'b1;
    end
    check(n == exp_n, {tag, " extend answer delay"}, n, exp_n);
    err_t = 1'b0;
    err_f = 1'b0;
  endtask

  initial begin
    logic hold;
    logic hold2;
    int n;
    repeat (3) @(negedge clk);
    check(!l_ack && !le_req && !r_req && !re_ack && !latch_en, "R1 reset outputs", int'(latch_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!l_ack && !le_req && !r_req && !re_ack && !latch_en, "R1 after release", int'(r_req), 0);

    for (int d = 2; d <= 5; d++) begin
      for (int w = 0; w <= d; w++) begin
        @(negedge clk);
        cfg_short = CW'(d);
        cfg_long = CW'(w);
        @(negedge clk);
        check(cfg_bad == 1'b0, "R8 legal setting", int'(cfg_bad), 0);
        run_fwd(1);
        run_fwd(2);
        run_fwd(d + w + 1);
        run_ext(0);
        run_ext(1);
        run_ext(2);
      end
    end

    // R7 neutral rails hold the answer back
    @(negedge clk);
    cfg_short = 4'd3; cfg_long = 4'd2;
    hold = re_ack;
    re_req = ~re_req;
    repeat (6) @(negedge clk);
    check(re_ack == hold, "R7 neutral rails no answer", int'(re_ack), int'(hold));
    err_f = 1'b1;
    @(negedge clk);
    check(re_ack != hold, "R7 answer once clean", int'(re_ack), int'(~hold));
    err_f = 1'b0;

    // R8 illegal settings
    cfg_short = 4'd3; cfg_long = 4'd4;
    @(negedge clk);
    check(cfg_bad == 1'b1, "R8 long above short flagged", int'(cfg_bad), 1);
    hold = le_req; hold2 = l_ack;
    up_lat = 1;
    l_req = ~l_req;
    repeat (6) @(negedge clk);
    check(le_req == hold, "R8 no extend request while bad", int'(le_req), int'(hold));
    check(l_ack == hold2, "R8 no left ack while bad", int'(l_ack), int'(hold2));
    cfg_short = 4'd1; cfg_long = 4'd0;
    @(negedge clk);
    check(cfg_bad == 1'b1, "R8 short below two flagged", int'(cfg_bad), 1);
    cfg_short = 4'd3; cfg_long = 4'd1;
    n = 0;
    while (l_ack != l_req && n < 30) begin @(negedge clk); n = n + 1; end
    check(n == 4, "R8 accepted after fix", n, 4);

    // R9 stalled right side blocks acceptance
    @(negedge clk);
    dn_auto = 1'b0;
    run_fwd(1);
    @(negedge clk);
    hold = le_req; hold2 = l_ack;
    l_req = ~l_req;
    repeat (6) @(negedge clk);
    check(le_req == hold, "R9 no accept while right busy", int'(le_req), int'(hold));
    check(l_ack == hold2, "R9 no left ack while right busy", int'(l_ack), int'(hold2));
    r_ack = r_req;
    hold = r_req;
    n = 0;
    while (r_req == hold && n < 30) begin @(posedge clk); @(negedge clk); n = n + 1; end
    check(n == 4, "R9 forward after right ack", n, 4);
    dn_auto = 1'b1;

    repeat (3) @(negedge clk);
    summary();
  end
endmodule